// File: doc/BRIEF.md
# Mode-multiplexed device access register

This block is a single 8-bit register on a host register bus. Through it the host talks to one of several side devices at a time. While the block is in select mode, a read reports which device is attached and a write can pick another device. Once the host leaves select mode, every access to the register goes to the attached device. A write with bit 7 set always brings the host back to select mode.

Two devices sit behind the register. The first is a serial identifier. Each read returns one bit. The stream starts with an 8-bit length prefix and then gives the identifier value, most significant bit first. The second is the control and status port of an ADC monitor. It has sticky end-of-conversion and end-of-sequence flags that a read clears, and it has one-cycle reset and conversion-start strobes.

The bus uses plain strobes and applies no back-pressure. Each access completes in one cycle. Read data is registered. It appears on the cycle after the read strobe and holds until the next read. The host never asserts the read and write strobes in the same cycle. If it does, the write is performed and the read is dropped. There is no valid/ready stream at the edge, because every transfer is a single register access.

Top module: `devmux_reg`

## Requirements
- R1: After reset the block is in select mode with device code 00, `reg_rdata_o` is 0x80, both strobes are low and both ADC flags are clear.
- R2: A read in select mode returns bit 7 = 1, bits 6:2 = 0 and bits 1:0 = the current device code (00 none, 01 identifier, 10 ADC monitor).
- R3: In select mode, a write with bits 7 and 6 set loads the device code from bits 1:0, except that code 11 is rejected and the old code is kept. A write with bit 7 set and bit 6 clear keeps the code.
- R4: In select mode, a write with bit 7 clear leaves select mode. The device code stays the same, no strobe fires, and the identifier position does not change.
- R5: In device mode, a write with bit 7 set returns to select mode and does nothing else: the device code, the identifier position and the ADC flags are unchanged, and no strobe fires.
- R6: In identifier mode, each read returns the next stream bit in bit 0 and zero in bits 7:1. The stream is the 8-bit value ID_BITS (MSB first), then `id_value_i` (MSB first), then zeros. Each read advances the stream by one bit.
- R7: In identifier mode, a write with bit 7 clear restarts the stream at the first length bit.
- R8: In ADC mode, a read returns {0, busy, 0000, eoc, eos}. Busy is the live `adc_busy_i`. The flags are set by one-cycle `adc_eoc_i`/`adc_eos_i` events in any mode and are cleared by an ADC-mode read.
- R9: An event that arrives in the same cycle as a clearing read is not shown by that read. The flag stays set and appears on the next read.
- R10: In ADC mode, a write with bit 7 clear raises `adc_rst_o` when bit 6 is set and `adc_convst_o` when bit 0 is set. Each strobe lasts exactly the one cycle after the write. No other write raises either strobe.
- R11: With code 00 attached in device mode, reads return 0x00 and writes with bit 7 clear have no effect.
- R12: `reg_rdata_o` changes only on the cycle after a read and holds its value across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (the soft reset) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| id_value_i | input | ID_BITS | Identifier value from the identifier primitive |
| adc_busy_i | input | 1 | ADC conversion busy |
| adc_eoc_i | input | 1 | One-cycle end-of-conversion event |
| adc_eos_i | input | 1 | One-cycle end-of-sequence event |
| adc_rst_o | output | 1 | One-cycle ADC reset strobe |
| adc_convst_o | output | 1 | One-cycle conversion-start strobe |

## Verification
The assertions assume three things about the inputs. The host never asserts both strobes in the same cycle. The ADC events are single-cycle pulses. `id_value_i` is held constant while the stream is being read. The bench keeps both strobes mutually exclusive by construction and holds the identifier value fixed for the whole run. It asserts the event inputs for one cycle at a time, at random, so events often coincide with clearing reads and with mode changes.

// File: rtl/devmux_pkg.sv
package devmux_pkg;
  typedef enum logic [1:0] {
    DEV_NONE   = 2'b00,
    DEV_SERID  = 2'b01,
    DEV_ADCMON = 2'b10
  } dev_e;

  localparam int REG_W         = 8;
  localparam int BIT_SEL       = 7;
  localparam int BIT_CHG       = 6;
  localparam int BIT_ADC_RST   = 6;
  localparam int BIT_ADC_START = 0;
  localparam int LEN_W         = 8;
endpackage

// File: rtl/devmux_mode.sv
module devmux_mode
  import devmux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       sel_bit_i,
  input  logic       chg_bit_i,
  input  logic [1:0] code_i,
  output logic       sel_mode_o,
  output dev_e       dev_o
);

  logic code_ok;
  assign code_ok = (code_i != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_mode_o <= 1'b1;
      dev_o      <= DEV_NONE;
    end else if (wr_i) begin
      if (sel_bit_i) begin
        sel_mode_o <= 1'b1;
        if (sel_mode_o && chg_bit_i && code_ok)
          dev_o <= dev_e'(code_i);
      end else begin
        sel_mode_o <= 1'b0;
      end
    end
  end

  // R5
  reenter_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_bit_i && !sel_mode_o) |=> (sel_mode_o && $stable(dev_o)));

  // R4
  leave_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !sel_bit_i && sel_mode_o) |=> (!sel_mode_o && $stable(dev_o)));

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_o != dev_e'(2'b11));

endmodule

// File: rtl/devmux_idstream.sv
module devmux_idstream
  import devmux_pkg::*;
#(
  parameter int ID_BITS = 57
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic               reload_i,
  input  logic [ID_BITS-1:0] id_value_i,
  output logic               bit_o
);

  localparam int TOTAL = ID_BITS + LEN_W;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] LAST = IW'(TOTAL);
  localparam logic [LEN_W-1:0] LEN_V = LEN_W'(ID_BITS);

  logic [IW-1:0]    pos;
  logic [TOTAL-1:0] frame;
  logic [TOTAL-1:0] shifted;

  assign frame   = {LEN_V, id_value_i};
  assign shifted = frame << pos;
  assign bit_o   = shifted[TOTAL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (reload_i) begin
      pos <= '0;
    end else if (adv_i && (pos != LAST)) begin
      pos <= pos + 1'b1;
    end
  end

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (bit_o == LEN_V[LEN_W-1]));

  // R6
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);

  // R6
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == LAST) |-> !bit_o);

endmodule

// File: rtl/devmux_adcflags.sv
module devmux_adcflags (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr_i,
  input  logic rst_bit_i,
  input  logic start_bit_i,
  input  logic clr_i,
  input  logic eoc_i,
  input  logic eos_i,
  output logic eoc_o,
  output logic eos_o,
  output logic adc_rst_o,
  output logic adc_convst_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_o        <= 1'b0;
      eos_o        <= 1'b0;
      adc_rst_o    <= 1'b0;
      adc_convst_o <= 1'b0;
    end else begin
      eoc_o        <= eoc_i | (eoc_o & ~clr_i);
      eos_o        <= eos_i | (eos_o & ~clr_i);
      adc_rst_o    <= cmd_wr_i & rst_bit_i;
      adc_convst_o <= cmd_wr_i & start_bit_i;
    end
  end

  // R9
  eoc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_i |=> eoc_o);

  // R9
  eos_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_i |=> eos_o);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !eoc_i && !eos_i) |=> (!eoc_o && !eos_o));

  // R10
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convst_o |-> $past(cmd_wr_i && start_bit_i));

  // R10
  reset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_rst_o |-> $past(cmd_wr_i && rst_bit_i));

endmodule

// File: rtl/devmux_reg.sv
module devmux_reg
  import devmux_pkg::*;
#(
  parameter int ID_BITS = 57
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [ID_BITS-1:0] id_value_i,
  input  logic               adc_busy_i,
  input  logic               adc_eoc_i,
  input  logic               adc_eos_i,
  output logic               adc_rst_o,
  output logic               adc_convst_o
);

  localparam logic [REG_W-1:0] RST_VAL = 8'h80;

  logic       sel_mode;
  dev_e       dev;
  logic       rd_acc;
  logic       dev_wr;
  logic       id_adv;
  logic       id_reload;
  logic       id_bit;
  logic       adc_cmd;
  logic       adc_clr;
  logic       eoc_flag;
  logic       eos_flag;
  logic [REG_W-1:0] rd_next;
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata_i[5:2];

  assign rd_acc    = reg_rd_i & ~reg_wr_i;
  assign dev_wr    = reg_wr_i & ~reg_wdata_i[BIT_SEL] & ~sel_mode;
  assign id_reload = dev_wr & (dev == DEV_SERID);
  assign adc_cmd   = dev_wr & (dev == DEV_ADCMON);
  assign id_adv    = rd_acc & ~sel_mode & (dev == DEV_SERID);
  assign adc_clr   = rd_acc & ~sel_mode & (dev == DEV_ADCMON);

  devmux_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr_i),
    .sel_bit_i  (reg_wdata_i[BIT_SEL]),
    .chg_bit_i  (reg_wdata_i[BIT_CHG]),
    .code_i     (reg_wdata_i[1:0]),
    .sel_mode_o (sel_mode),
    .dev_o      (dev)
  );

  devmux_idstream #(.ID_BITS(ID_BITS)) u_id (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (id_adv),
    .reload_i   (id_reload),
    .id_value_i (id_value_i),
    .bit_o      (id_bit)
  );

  devmux_adcflags u_adc (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr_i     (adc_cmd),
    .rst_bit_i    (reg_wdata_i[BIT_ADC_RST]),
    .start_bit_i  (reg_wdata_i[BIT_ADC_START]),
    .clr_i        (adc_clr),
    .eoc_i        (adc_eoc_i),
    .eos_i        (adc_eos_i),
    .eoc_o        (eoc_flag),
    .eos_o        (eos_flag),
    .adc_rst_o    (adc_rst_o),
    .adc_convst_o (adc_convst_o)
  );

  always_comb begin
    rd_next = '0;
    if (sel_mode) begin
      rd_next[BIT_SEL] = 1'b1;
      rd_next[1:0]     = dev;
    end else begin
      case (dev)
        DEV_SERID:  rd_next[0] = id_bit;
        DEV_ADCMON: begin
          rd_next[6] = adc_busy_i;
          rd_next[1] = eoc_flag;
          rd_next[0] = eos_flag;
        end
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata_o <= RST_VAL;
    else if (rd_acc) reg_rdata_o <= rd_next;
  end

  // R2
  sel_read_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel_mode) |=> (reg_rdata_o[7] && (reg_rdata_o[6:2] == 5'b0)));

  // R11
  none_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !sel_mode && (dev == DEV_NONE)) |=> (reg_rdata_o == 8'h00));

  // R6
  id_read_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !sel_mode && (dev == DEV_SERID)) |=> (reg_rdata_o[7:1] == 7'b0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(reg_rdata_o));

endmodule

// File: tb/tb_devmux_reg.sv
module tb_devmux_reg;
  localparam int CLK_PERIOD = 10;
  localparam int ID_BITS    = 57;
  localparam int TOTAL      = ID_BITS + 8;
  localparam logic [ID_BITS-1:0] ID_VAL = {25'h1A5F00D, 32'hCAFE1234};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic adc_busy = 1'b0;
  logic adc_eoc = 1'b0;
  logic adc_eos = 1'b0;
  logic adc_rst;
  logic adc_convst;

  int errors = 0;
  int checks = 0;

  logic       m_sel;
  logic [1:0] m_dev;
  int         m_pos;
  logic       m_eoc;
  logic       m_eos;
  logic [7:0] m_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  devmux_reg #(.ID_BITS(ID_BITS)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_i     (reg_wr),
    .reg_rd_i     (reg_rd),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .id_value_i   (ID_VAL),
    .adc_busy_i   (adc_busy),
    .adc_eoc_i    (adc_eoc),
    .adc_eos_i    (adc_eos),
    .adc_rst_o    (adc_rst),
    .adc_convst_o (adc_convst)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic idbit(input int p);
    logic [TOTAL-1:0] f;
    f = {8'(ID_BITS), ID_VAL} << p;
    return f[TOTAL-1];
  endfunction

  function automatic logic [7:0] model_read(input logic b);
    logic [7:0] r;
    r = 8'h00;
    if (m_sel) r = {1'b1, 5'b0, m_dev};
    else if (m_dev == 2'b01) r[0] = idbit(m_pos);
    else if (m_dev == 2'b10) r = {1'b0, b, 4'b0, m_eoc, m_eos};
    return r;
  endfunction

  task automatic op(input logic wr, input logic rd, input logic [7:0] w,
                    input logic e1, input logic e2, input logic b, input string tag);
    logic xr;
    logic xc;
    string t;
    t = tag;
    if (t == "") begin
      if (rd && !wr) begin
        if (m_sel) t = "R2";
        else if (m_dev == 2'b01) t = "R6";
        else if (m_dev == 2'b10) t = "R8";
        else t = "R11";
      end else t = "R12";
    end
    reg_wr = wr; reg_rd = rd; wdata = w;
    adc_eoc = e1; adc_eos = e2; adc_busy = b;
    xr = wr && !m_sel && (m_dev == 2'b10) && !w[7] && w[6];
    xc = wr && !m_sel && (m_dev == 2'b10) && !w[7] && w[0];
    if (rd && !wr) m_last = model_read(b);
    if (wr) begin
      if (m_sel) begin
        if (w[7]) begin
          if (w[6] && (w[1:0] != 2'b11)) m_dev = w[1:0];
        end else m_sel = 1'b0;
      end else begin
        if (w[7]) m_sel = 1'b1;
        else if (m_dev == 2'b01) m_pos = 0;
      end
    end else if (rd && !m_sel) begin
      if (m_dev == 2'b01 && m_pos < TOTAL) m_pos++;
      if (m_dev == 2'b10) begin m_eoc = 1'b0; m_eos = 1'b0; end
    end
    if (e1) m_eoc = 1'b1;
    if (e2) m_eos = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(t, rdata, m_last);
    chk("R10", {6'b0, adc_rst, adc_convst}, {6'b0, xr, xc});
    reg_wr = 1'b0; reg_rd = 1'b0; adc_eoc = 1'b0; adc_eos = 1'b0;
  endtask

  task automatic wr_op(input logic [7:0] w, input string tag);
    op(1'b1, 1'b0, w, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd_op(input string tag);
    op(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    m_sel = 1'b1; m_dev = 2'b00; m_pos = 0; m_eoc = 1'b0; m_eos = 1'b0; m_last = 8'h80;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rdata, 8'h80);
    chk("R1", {6'b0, adc_rst, adc_convst}, 8'h00);
    rd_op("R1");

    // R3 selection rules
    wr_op(8'hC1, "R3");
    rd_op("R3");
    wr_op(8'hC3, "R3");
    rd_op("R3");
    wr_op(8'h82, "R3");
    rd_op("R3");

    // R4 exit into identifier mode, then read full stream
    wr_op(8'h3F, "R4");
    for (int i = 0; i < TOTAL + 2; i++) rd_op("R6");

    // R7 restart
    wr_op(8'h00, "R7");
    for (int i = 0; i < 3; i++) rd_op("R7");

    // R5 re-enter select, no side effects
    wr_op(8'hFF, "R5");
    rd_op("R5");
    wr_op(8'h00, "R4");
    for (int i = 0; i < 4; i++) rd_op("R5");

    // ADC mode flags
    wr_op(8'hC2, "R3");
    wr_op(8'h00, "R4");
    op(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R12");
    op(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
    rd_op("R8");
    op(1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
    op(1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, "R9");
    rd_op("R9");
    rd_op("R9");

    // R10 strobes
    wr_op(8'h41, "R10");
    wr_op(8'h40, "R10");
    wr_op(8'h01, "R10");
    wr_op(8'hC1, "R5");
    rd_op("R5");

    // R11 no device attached
    wr_op(8'hC0, "R3");
    wr_op(8'h00, "R4");
    wr_op(8'h7F, "R11");
    rd_op("R11");
    wr_op(8'h80, "R5");
    rd_op("R11");

    // constrained random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] w;
      int k;
      k = int'($urandom % 10);
      w = 8'($urandom);
      if (k < 4) begin
        op(1'b0, 1'b1, 8'h00, ($urandom % 6) == 0, ($urandom % 9) == 0, 1'($urandom), "");
      end else if (k < 6) begin
        w[7] = 1'b1;
        w[6] = 1'b1;
        op(1'b1, 1'b0, w, ($urandom % 6) == 0, ($urandom % 9) == 0, 1'($urandom), "");
      end else if (k < 7) begin
        w[7] = 1'b1;
        op(1'b1, 1'b0, w, 1'b0, 1'b0, 1'($urandom), "");
      end else if (k < 9) begin
        w[7] = 1'b0;
        op(1'b1, 1'b0, w, ($urandom % 6) == 0, 1'b0, 1'($urandom), "");
      end else begin
        op(1'b0, 1'b0, 8'h00, ($urandom % 3) == 0, ($urandom % 3) == 0, 1'($urandom), "");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule